// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is a bus target for a two-wire SMBus/I2C-style link. It serves a nine-byte configuration register file to a host, and the neighbouring clock-distribution logic uses that file to enable or disable each of nineteen outputs. SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer and a glitch filter before start, repeated start, stop and SCL edges are decoded. The target pulls SDA low through an open-drain enable. It never stretches the clock.

Every access opens with an index byte. In a write, the host sends the index, then a byte count, then that many data bytes, and the data fill consecutive registers. In a read, the host sets the index, issues a repeated start and addresses the target for reading. The target first returns a count taken from its own writable count field, then the registers from the index onward. The 7-bit target address comes from two tri-level strap inputs, which arrive already resolved to codes. Those straps, the two mode straps and the frequency strap are captured once after reset.

The link only responds while `ref_ok` reports that the reference clock is running.

Top module: `smb_cfg_target`

## Requirements
- R1: The strap pair (hi, lo), each coded 0 = low, 1 = mid, 2 = high, with 3 taken as high, selects the 8-bit write address. The mapping is 00→D8, 01→DA, 02→DE, 10→C2, 11→C4, 12→C6, 20→CA, 21→CC, 22→CE, and the 7-bit address is bits 7:1. A byte naming another address is not acknowledged, and the block ignores the bus until the next start.
- R2: In a write, the address, index, count and each data byte within the count are acknowledged by driving SDA low for the ninth clock. Data byte k is stored at register index+k.
- R3: The register pointer advances after every data byte written or read, and wraps from register 8 to register 0. An index byte above 8 selects register 0.
- R4: A data byte beyond the host's count is not acknowledged and not stored.
- R5: A read first returns the count field (register 7 bits 4:0) as a byte. It then returns count+1 register bytes from the pointer onward. Any further byte the host clocks out reads as FF.
- R6: A host NACK ends a read, and SDA is released.
- R7: Reset values are as follows. Register 0 = {mode strap[1:0], 3'b111, 2'b00, frequency strap}. Registers 1 and 2 = FF. Registers 3, 4 and 8 = 00. Register 5 = {revision 1, vendor 1} = 11. Register 6 = C3. Register 7 = 08.
- R8: The only writable bits are register 0 bits 5:3, all of registers 1 and 2, and register 7 bits 4:0. Writes to any other bit are acknowledged and then have no effect.
- R9: `out_en` bit k is register 1 bit k for k = 0..7, register 2 bit k-8 for k = 8..15, and register 0 bit k-13 for k = 16..18.
- R10: A stop, or a start arriving mid-transaction, abandons the transaction. A partly received byte is not stored.
- R11: While `ref_ok` is low, SDA is released, nothing is acknowledged and any transaction is dropped.
- R12: A pulse on SCL or SDA shorter than FILT_LEN system clocks (3 by default) has no effect.
- R13: The straps are captured in the first cycle after reset. Later changes have no effect on the address or on register 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ok | input | 1 | Reference clock running; the link is inactive when low |
| strap_addr_hi | input | 2 | Resolved tri-level code of the upper address strap |
| strap_addr_lo | input | 2 | Resolved tri-level code of the lower address strap |
| strap_mode | input | 2 | Mode strap, read back in register 0 bits 7:6 |
| strap_freq | input | 1 | Frequency strap, read back in register 0 bit 0 |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| out_en | output | 19 | Per-output enable bits |

## Verification
The assertions assume a host that changes SDA only while SCL is low, except when it forms a start or stop. They also assume every SCL level lasts well beyond the synchronizer and filter latency, so the target's own SDA changes, made after a filtered SCL fall, never look like bus conditions. The bench host holds each SCL phase for ten system clocks and moves SDA a full phase after each falling edge. The only short pulses it creates are the deliberate glitches, kept at one or two clocks and below the filter length.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned NUM_REGS = 9;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned CNT_W    = 5;
  localparam int unsigned NUM_OUT  = 19;
  localparam int unsigned REG_CTL  = 0;
  localparam int unsigned REG_ENLO = 1;
  localparam int unsigned REG_ENHI = 2;
  localparam int unsigned REG_IDS  = 5;
  localparam int unsigned REG_DEV  = 6;
  localparam int unsigned REG_CNT  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_ACK_PEND, S_ACK_DRIVE, S_SEND, S_ACK_RECV, S_SEND_NEXT
  } smb_state_e;

  typedef enum logic [1:0] {K_ADDR, K_INDEX, K_COUNT, K_DATA} smb_kind_e;

  // tri-level code to 0/1/2; code 3 counts as high
  function automatic int unsigned smb_tri(input logic [1:0] code);
    return (code == 2'd3) ? 2 : int'(code);
  endfunction

  function automatic logic [6:0] smb_dev_addr(input logic [1:0] hi, input logic [1:0] lo);
    logic [7:0] a8;
    case (smb_tri(hi) * 3 + smb_tri(lo))
      0: a8 = 8'hD8;
      1: a8 = 8'hDA;
      2: a8 = 8'hDE;
      3: a8 = 8'hC2;
      4: a8 = 8'hC4;
      5: a8 = 8'hC6;
      6: a8 = 8'hCA;
      7: a8 = 8'hCC;
      default: a8 = 8'hCE;
    endcase
    return a8[7:1];
  endfunction

  function automatic logic [IDX_W-1:0] smb_next_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(NUM_REGS - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] smb_start_idx(input logic [7:0] b);
    return (b < 8'(NUM_REGS)) ? b[IDX_W-1:0] : '0;
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = filt_q;

  // R12: the filtered level only ever takes a value the synchronizer had
  a_r12_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q));
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter logic [3:0] REV_ID    = 4'h1,
  parameter logic [3:0] VENDOR_ID = 4'h1,
  parameter logic [7:0] DEV_ID    = 8'hC3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         strap_addr_hi,
  input  logic [1:0]         strap_addr_lo,
  input  logic [1:0]         strap_mode,
  input  logic               strap_freq,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [7:0]         rd_data,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [6:0]         dev_addr,
  output logic [NUM_OUT-1:0] out_en
);
  logic             done_q;
  logic [1:0]       mode_q;
  logic             freq_q;
  logic [6:0]       addr_q;
  logic [2:0]       en_top_q;
  logic [7:0]       en_lo_q;
  logic [7:0]       en_hi_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mode_q <= '0;
      freq_q <= 1'b0;
      addr_q <= '0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      mode_q <= strap_mode;
      freq_q <= strap_freq;
      addr_q <= smb_dev_addr(strap_addr_hi, strap_addr_lo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_top_q <= 3'b111;
      en_lo_q  <= 8'hFF;
      en_hi_q  <= 8'hFF;
      cnt_q    <= CNT_W'(8);
    end else if (wr_en) begin
      case (int'(wr_idx))
        REG_CTL:  en_top_q <= wr_data[5:3];
        REG_ENLO: en_lo_q  <= wr_data;
        REG_ENHI: en_hi_q  <= wr_data;
        REG_CNT:  cnt_q    <= wr_data[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (int'(rd_idx))
      REG_CTL:  rd_data = {mode_q, en_top_q, 2'b00, freq_q};
      REG_ENLO: rd_data = en_lo_q;
      REG_ENHI: rd_data = en_hi_q;
      REG_IDS:  rd_data = {REV_ID, VENDOR_ID};
      REG_DEV:  rd_data = DEV_ID;
      REG_CNT:  rd_data = {{(8 - CNT_W){1'b0}}, cnt_q};
      default:  rd_data = 8'h00;
    endcase
  end

  assign cnt_o    = cnt_q;
  assign dev_addr = addr_q;
  assign out_en   = {en_top_q, en_hi_q, en_lo_q};

  // R3: the pointer handed over by the protocol engine stays in the file
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS));
  // R8: count field changes only through a write to its register
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && int'(wr_idx) == REG_CNT) |=> $stable(cnt_q));
  // R13: captured straps never move after the capture cycle
  a_r13_straps_held: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> ($stable(addr_q) && $stable(mode_q) && $stable(freq_q)));
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 3,
  parameter logic [3:0]  REV_ID    = 4'h1,
  parameter logic [3:0]  VENDOR_ID = 4'h1,
  parameter logic [7:0]  DEV_ID    = 8'hC3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_ok,
  input  logic [1:0]         strap_addr_hi,
  input  logic [1:0]         strap_addr_lo,
  input  logic [1:0]         strap_mode,
  input  logic               strap_freq,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] out_en
);
  // ---- line conditioning ----
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // ---- named bus events ----
  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

  // ---- protocol state ----
  smb_state_e       st_q;
  smb_kind_e        kind_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [7:0]       tx_q;
  logic [IDX_W-1:0] ptr_q;
  logic [7:0]       wr_left_q;
  logic [CNT_W:0]   rd_left_q;
  logic             rd_mode_q;
  logic             need_cnt_q;
  logic             sda_oe_q;

  logic [7:0]       rx_byte;
  logic             byte_done;
  logic             ack_ok;
  logic             wr_en;
  logic             load_now;
  logic [7:0]       load_byte;
  logic [7:0]       rd_data;
  logic [CNT_W-1:0] cnt;
  logic [6:0]       dev_addr;

  assign rx_byte   = {sh_q[6:0], sda_f};
  assign byte_done = (st_q == S_RECV) && scl_rise && (bit_q == 3'd7);
  assign wr_en     = byte_done && (kind_q == K_DATA) && (wr_left_q != 8'd0);
  assign load_now  = scl_fall && (((st_q == S_ACK_DRIVE) && rd_mode_q) || (st_q == S_SEND_NEXT));

  always_comb begin
    case (kind_q)
      K_ADDR:  ack_ok = (rx_byte[7:1] == dev_addr);
      K_DATA:  ack_ok = (wr_left_q != 8'd0);
      default: ack_ok = 1'b1;
    endcase
  end

  always_comb begin
    if (need_cnt_q)             load_byte = {{(8 - CNT_W){1'b0}}, cnt};
    else if (rd_left_q != '0)   load_byte = rd_data;
    else                        load_byte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      kind_q     <= K_ADDR;
      bit_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      wr_left_q  <= '0;
      rd_left_q  <= '0;
      rd_mode_q  <= 1'b0;
      need_cnt_q <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (!ref_ok) begin
      st_q     <= S_IDLE;
      sda_oe_q <= 1'b0;
    end else if (bus_start) begin
      st_q      <= S_RECV;
      kind_q    <= K_ADDR;
      bit_q     <= '0;
      rd_mode_q <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (bus_stop) begin
      st_q     <= S_IDLE;
      sda_oe_q <= 1'b0;
    end else if (load_now) begin
      tx_q     <= load_byte;
      sda_oe_q <= ~load_byte[7];
      bit_q    <= '0;
      st_q     <= S_SEND;
      if (need_cnt_q) begin
        need_cnt_q <= 1'b0;
      end else if (rd_left_q != '0) begin
        rd_left_q <= rd_left_q - 1'b1;
        ptr_q     <= smb_next_idx(ptr_q);
      end
    end else begin
      case (st_q)
        S_RECV: if (scl_rise) begin
          sh_q  <= rx_byte;
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            st_q <= ack_ok ? S_ACK_PEND : S_IDLE;
            case (kind_q)
              K_ADDR: begin
                rd_mode_q <= rx_byte[0];
                kind_q    <= K_INDEX;
                if (rx_byte[0]) begin
                  need_cnt_q <= 1'b1;
                  rd_left_q  <= {1'b0, cnt} + 1'b1;
                end
              end
              K_INDEX: begin
                ptr_q  <= smb_start_idx(rx_byte);
                kind_q <= K_COUNT;
              end
              K_COUNT: begin
                wr_left_q <= rx_byte;
                kind_q    <= K_DATA;
              end
              default: if (wr_left_q != 8'd0) begin
                wr_left_q <= wr_left_q - 1'b1;
                ptr_q     <= smb_next_idx(ptr_q);
              end
            endcase
          end
        end
        S_ACK_PEND: if (scl_fall) begin
          sda_oe_q <= 1'b1;
          st_q     <= S_ACK_DRIVE;
        end
        S_ACK_DRIVE: if (scl_fall) begin
          sda_oe_q <= 1'b0;
          st_q     <= S_RECV;
          bit_q    <= '0;
        end
        S_SEND: if (scl_fall) begin
          if (bit_q == 3'd7) begin
            sda_oe_q <= 1'b0;
            st_q     <= S_ACK_RECV;
          end else begin
            tx_q     <= tx_q << 1;
            sda_oe_q <= ~tx_q[6];
            bit_q    <= bit_q + 1'b1;
          end
        end
        S_ACK_RECV: if (scl_rise) begin
          st_q <= sda_f ? S_IDLE : S_SEND_NEXT;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  smb_cfg_regs #(
    .REV_ID    (REV_ID),
    .VENDOR_ID (VENDOR_ID),
    .DEV_ID    (DEV_ID)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_addr_hi (strap_addr_hi),
    .strap_addr_lo (strap_addr_lo),
    .strap_mode    (strap_mode),
    .strap_freq    (strap_freq),
    .wr_en         (wr_en),
    .wr_idx        (ptr_q),
    .wr_data       (rx_byte),
    .rd_idx        (ptr_q),
    .rd_data       (rd_data),
    .cnt_o         (cnt),
    .dev_addr      (dev_addr),
    .out_en        (out_en)
  );

  // R11: a dead reference clock releases the line on the next cycle
  a_r11_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> !sda_oe_q);
  // R10: a stop always lands the engine in idle
  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ok && bus_stop) |=> (st_q == S_IDLE));
  // R2: the target only moves SDA while the filtered clock is low
  a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ok && $past(ref_ok) && !$past(bus_start) && !$past(bus_stop)
     && (sda_oe_q != $past(sda_oe_q))) |-> !scl_f);
  // R5: the first byte sent after a read address is the count field
  a_r5_count_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ok && !bus_start && !bus_stop && scl_fall && st_q == S_ACK_DRIVE && rd_mode_q)
    |=> (tx_q == {{(8 - CNT_W){1'b0}}, $past(cnt)}));
endmodule

// File: tb/test_smb_cfg_target.sv
module test_smb_cfg_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ok = 1'b1;
  logic [1:0] s_hi = 2'd2, s_lo = 2'd1, s_mode = 2'b11;
  logic s_freq = 1'b1;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [18:0] out_en;
  logic sda_bus;
  assign sda_bus = sda_h & ~sda_oe;

  always #10 clk = ~clk;

  smb_cfg_target i_smb_cfg_target (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok),
    .strap_addr_hi(s_hi), .strap_addr_lo(s_lo), .strap_mode(s_mode), .strap_freq(s_freq),
    .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe), .out_en(out_en)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] rbuf [16];
  logic [7:0] my_addr = 8'hCC;

  localparam logic [7:0] ADDR_TBL [9] = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4,
                                          8'hC6, 8'hCA, 8'hCC, 8'hCE};
  // {index, written value, expected readback, expected count byte}
  localparam logic [31:0] VEC [9] = '{
    {8'd1, 8'h5A, 8'h5A, 8'h08},   // R2 full register
    {8'd2, 8'hA5, 8'hA5, 8'h08},   // R2
    {8'd0, 8'h00, 8'hC1, 8'h08},   // R8 only bits 5:3 move
    {8'd3, 8'hFF, 8'h00, 8'h08},   // R8 reserved
    {8'd4, 8'h55, 8'h00, 8'h08},   // R8 reserved
    {8'd5, 8'h00, 8'h11, 8'h08},   // R8 id
    {8'd6, 8'h00, 8'hC3, 8'h08},   // R8 device id
    {8'd8, 8'h77, 8'h00, 8'h08},   // R8 reserved
    {8'd7, 8'hE3, 8'h03, 8'h03}    // R8 count bits 4:0 only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); b = sda_bus; wq(); scl_h = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~ack_it);
  endtask

  // n data bytes sent, host count field hc; bytes past hc expect NACK
  task automatic write_tx(input logic [7:0] idx, input logic [7:0] hc, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(my_addr, a);  chk("R2 address ack", a, 1);
    send_byte(idx, a);      chk("R2 index ack", a, 1);
    send_byte(hc, a);       chk("R2 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      if (i < int'(hc)) chk("R2 data ack", a, 1);
      else              chk("R4 excess byte nack", a, 0);
    end
    bus_stop();
  endtask

  task automatic read_tx(input logic [7:0] idx, input int nread);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(my_addr, a);  chk("R2 address ack", a, 1);
    send_byte(idx, a);      chk("R2 index ack", a, 1);
    bus_start();
    send_byte(my_addr | 8'h01, a); chk("R5 read address ack", a, 1);
    for (int i = 0; i < nread; i++) begin
      recv_byte(i != nread - 1, v);
      rbuf[i] = v;
    end
    chk("R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic a;
    do_reset();
    chk("R7 reset sda released", sda_oe, 0);
    chk("R9 reset enables", out_en, 19'h7FFFF);

    // R7 defaults through a full read; R5 count then count+1 bytes, then FF
    read_tx(8'd0, 11);
    chk("R5 count byte", rbuf[0], 8'h08);
    chk("R7 reg0", rbuf[1], 8'hF9);
    chk("R7 reg1", rbuf[2], 8'hFF);
    chk("R7 reg2", rbuf[3], 8'hFF);
    chk("R7 reg3", rbuf[4], 8'h00);
    chk("R7 reg4", rbuf[5], 8'h00);
    chk("R7 reg5", rbuf[6], 8'h11);
    chk("R7 reg6", rbuf[7], 8'hC3);
    chk("R7 reg7", rbuf[8], 8'h08);
    chk("R7 reg8", rbuf[9], 8'h00);
    chk("R5 beyond count", rbuf[10], 8'hFF);

    foreach (VEC[k]) begin
      write_tx(VEC[k][31:24], 8'd1, 1, VEC[k][23:16], 8'h00, 8'h00);
      read_tx(VEC[k][31:24], 2);
      chk("R5 count byte vec", rbuf[0], {24'h0, VEC[k][7:0]});
      chk("R8 readback vec", rbuf[1], {24'h0, VEC[k][15:8]});
    end

    chk("R9 enables after table", out_en, 19'h0A55A);
    read_tx(8'd0, 6);       // count field is 3 now
    chk("R5 short count", rbuf[0], 8'h03);
    chk("R3 read seq 0", rbuf[1], 8'hC1);
    chk("R3 read seq 1", rbuf[2], 8'h5A);
    chk("R3 read seq 2", rbuf[3], 8'hA5);
    chk("R3 read seq 3", rbuf[4], 8'h00);
    chk("R5 past short count", rbuf[5], 8'hFF);

    // R3 wrap from register 8 to 0 on write
    write_tx(8'd7, 8'd1, 1, 8'h08, 8'h00, 8'h00);
    write_tx(8'd8, 8'd3, 3, 8'h11, 8'h22, 8'h33);
    read_tx(8'd8, 4);
    chk("R3 wrap reg8", rbuf[1], 8'h00);
    chk("R3 wrap reg0", rbuf[2], 8'hE1);
    chk("R3 wrap reg1", rbuf[3], 8'h33);
    chk("R9 enable mapping", out_en, 19'h4A533);

    // R4 byte beyond host count
    write_tx(8'd2, 8'd1, 2, 8'h44, 8'h55, 8'h00);
    read_tx(8'd2, 3);
    chk("R4 counted byte stored", rbuf[1], 8'h44);
    chk("R4 excess not stored", rbuf[2], 8'h00);

    // R3 index above the last register selects register 0
    write_tx(8'h20, 8'd1, 1, 8'h38, 8'h00, 8'h00);
    read_tx(8'd0, 2);
    chk("R3 out of range index", rbuf[1], 8'hF9);

    // R1 foreign address
    bus_start();
    send_byte(8'hD8, a); chk("R1 foreign address nack", a, 0);
    send_byte(8'h01, a); send_byte(8'h01, a); send_byte(8'h00, a);
    bus_stop();
    read_tx(8'd1, 2);
    chk("R1 foreign write ignored", rbuf[1], 8'h33);

    // R10 stop inside a data byte
    bus_start();
    send_byte(my_addr, a); send_byte(8'd1, a); send_byte(8'd1, a);
    send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    bus_stop();
    read_tx(8'd1, 2);
    chk("R10 stop abort", rbuf[1], 8'h33);

    // R10 start after the count byte abandons the write
    bus_start();
    send_byte(my_addr, a); send_byte(8'd2, a); send_byte(8'd1, a);
    bus_start();
    send_byte(my_addr | 8'h01, a); chk("R10 restart read ack", a, 1);
    recv_byte(1'b1, rbuf[0]);
    recv_byte(1'b0, rbuf[1]);
    bus_stop();
    chk("R10 restart data untouched", rbuf[1], 8'h44);

    // R11 reference clock absent
    ref_ok = 1'b0;
    bus_start();
    send_byte(my_addr, a); chk("R11 no ack when off", a, 0);
    bus_stop();
    chk("R11 line released", sda_oe, 0);
    ref_ok = 1'b1;

    // R12 short glitches on both lines during a write
    bus_start();
    send_byte(my_addr, a); send_byte(8'd1, a); send_byte(8'd1, a);
    for (int i = 7; i >= 0; i--) begin
      sda_h = (i < 4);
      repeat (3) @(negedge clk);
      scl_h = 1'b1; @(negedge clk); scl_h = 1'b0;   // 1-cycle SCL pulse
      repeat (Q - 4) @(negedge clk);
      scl_h = 1'b1; wq();
      if (i < 4) begin
        sda_h = 1'b0; repeat (2) @(negedge clk); sda_h = 1'b1;  // 2-cycle SDA dip
        repeat (Q - 2) @(negedge clk);
      end else wq();
      scl_h = 1'b0; wq();
    end
    recv_bit(a); chk("R12 ack despite glitches", a, 0);
    bus_stop();
    read_tx(8'd1, 2);
    chk("R12 glitches ignored", rbuf[1], 8'h0F);

    // R13 strap changes after reset
    s_mode = 2'b00; s_hi = 2'd0; s_lo = 2'd0;
    read_tx(8'd0, 2);
    chk("R13 mode strap held", rbuf[1], 8'hF9);

    // R1 every strap pair, plus code 3 as high; R13 capture after reset
    for (int c = 0; c < 10; c++) begin
      s_hi = (c == 9) ? 2'd3 : 2'(c / 3);
      s_lo = (c == 9) ? 2'd3 : 2'(c % 3);
      do_reset();
      my_addr = ADDR_TBL[(c == 9) ? 8 : c];
      bus_start();
      send_byte(my_addr, a); chk("R1 strap address ack", a, 1);
      bus_stop();
      bus_start();
      send_byte(ADDR_TBL[(c + 1) % 9], a); chk("R1 other address nack", a, 0);
      bus_stop();
    end
    read_tx(8'd0, 2);
    chk("R13 new mode strap after reset", rbuf[1], 8'h39);

    summary();
  end
endmodule